// File: doc/BRIEF.md
# ADC Conversion Trigger and Result Formatter

This block is the digital control shell around a 10-bit successive-approximation converter. A 3-bit mode input picks one start source from six: a software strobe, four timer-overflow pulses, or the rising edge of an asynchronous external pin. Once a start is accepted, the block raises a busy flag. It then runs a conversion clock derived from the system clock by a programmable divider and steps through three tracking periods and ten bit decisions.

A small behavioural converter stand-in resolves one result bit per decision period from the supplied raw code. On the last decision the block writes the 16-bit result pair in one step, drops busy and pulses a done flag for one cycle. The result can be aligned to the low end or the high end of the pair. It is read as unsigned when the negative-input select chooses ground, and as two's complement for any other negative-input select.

Top module: `adc_conv_ctrl`

## Requirements
- R1: With startMode 000 a swStart pulse starts a conversion. Modes 001, 010, 011 and 101 start on tmr0Ovf, tmr2Ovf, tmr1Ovf and tmr3Ovf respectively. A pulse on any source that the current mode does not select starts nothing.
- R2: In mode 100 a low-to-high transition of the asynchronous extStart pin starts a conversion, and busy is 1 within four clock cycles of the transition. A pin held high starts only one conversion.
- R3: Modes 110 and 111 start no conversion from any source.
- R4: busy is 1 for exactly 13*(clkSel+1) consecutive clock cycles. It rises in the cycle after the accepted trigger.
- R5: A trigger that arrives while busy is 1 is ignored, including one in the last busy cycle. It does not lengthen the conversion and does not add a done pulse.
- R6: done is 1 for exactly one cycle, which is the first cycle in which busy is 0 after a conversion. A trigger present in that cycle is accepted, so busy is 0 for only that one cycle.
- R7: When negSel is 0 (single-ended) and leftJust is 0, the result pair {resultHi,resultLo} is the 10-bit code with bits 15:10 cleared. Full scale reads 0x03FF.
- R8: With leftJust at 1 the code sits in bits 15:6 and bits 5:0 are 0, in both single-ended and differential operation. Full scale reads 0xFFC0, and the most negative differential code 0x200 reads 0x8000.
- R9: When negSel is nonzero (differential) and leftJust is 0, bits 15:10 copy code bit 9. Code 0x200 reads 0xFE00 and code 0x300 reads 0xFF00.
- R10: The result pair changes only in the cycle in which done is 1, and holds until the next completion. After reset busy, done and the result pair are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startMode | input | 3 | Start-source select |
| swStart | input | 1 | Software start strobe |
| tmr0Ovf | input | 1 | Timer 0 overflow pulse |
| tmr1Ovf | input | 1 | Timer 1 overflow pulse |
| tmr2Ovf | input | 1 | Timer 2 overflow pulse |
| tmr3Ovf | input | 1 | Timer 3 overflow pulse |
| extStart | input | 1 | Asynchronous external start pin |
| clkSel | input | 5 | Conversion clock divide select (divide by clkSel+1) |
| negSel | input | 4 | Negative-input select; 0 means ground (single-ended) |
| leftJust | input | 1 | 1 aligns the result to the high end of the pair |
| rawCode | input | 10 | Code that the converter stand-in resolves |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| resultHi | output | 8 | Result bits 15:8 |
| resultLo | output | 8 | Result bits 7:0 |

## Verification
Completion and a new start can fall in the same cycle. In the cycle where done pulses and busy has just dropped, a trigger still present must be taken at once. One cycle earlier, while busy is still 1 on the final decision, a trigger must be dropped. The bench provokes the first case by holding a timer overflow high across a whole conversion and checks that busy is low for exactly one cycle, with the first result already in the pair. It provokes the second by raising a timer overflow only in the last busy cycle, and expects busy to stay low afterwards with exactly one done pulse.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int CODE_W = 10;
  localparam int OUT_W  = 16;
  localparam int IDX_W  = $clog2(CODE_W);
  localparam int PAD_W  = OUT_W - CODE_W;

  typedef enum logic [2:0] {
    SRC_SW  = 3'd0,
    SRC_T0  = 3'd1,
    SRC_T2  = 3'd2,
    SRC_T1  = 3'd3,
    SRC_EXT = 3'd4,
    SRC_T3  = 3'd5
  } startSrc_e;

  typedef struct packed {
    logic             clear;
    logic             decide;
    logic [IDX_W-1:0] bitIdx;
    logic             finish;
  } ctlStrobes_t;
endpackage

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
  import adc_ctrl_pkg::*;
#(
  parameter int SEL_W     = 5,
  parameter int TRACK_CYC = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       startMode,
  input  logic             swStart,
  input  logic             tmr0Ovf,
  input  logic             tmr1Ovf,
  input  logic             tmr2Ovf,
  input  logic             tmr3Ovf,
  input  logic             extStart,
  input  logic [SEL_W-1:0] clkSel,
  output logic             busy,
  output logic             done,
  output ctlStrobes_t      strb
);
  localparam int TOTAL = TRACK_CYC + CODE_W;
  localparam int PH_W  = $clog2(TOTAL + 1);

  logic [2:0]       extSync;
  logic             extRise;
  logic             trigSel;
  logic             startNow;
  logic [SEL_W-1:0] divCnt;
  logic [PH_W-1:0]  phase;
  logic             tick;
  logic             lastTick;

  // two-stage synchroniser plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extSync <= '0;
    else       extSync <= {extSync[1:0], extStart};
  end
  assign extRise = extSync[1] & ~extSync[2];

  always_comb begin
    case (startMode)
      SRC_SW:  trigSel = swStart;
      SRC_T0:  trigSel = tmr0Ovf;
      SRC_T2:  trigSel = tmr2Ovf;
      SRC_T1:  trigSel = tmr1Ovf;
      SRC_EXT: trigSel = extRise;
      SRC_T3:  trigSel = tmr3Ovf;
      default: trigSel = 1'b0;
    endcase
  end

  assign startNow = trigSel & ~busy;
  assign tick     = busy && (divCnt >= clkSel);
  assign lastTick = tick && (phase == PH_W'(TOTAL - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      divCnt <= '0;
      phase  <= '0;
    end else begin
      done <= lastTick;
      if (startNow) begin
        busy   <= 1'b1;
        divCnt <= '0;
        phase  <= '0;
      end else if (busy) begin
        if (tick) begin
          divCnt <= '0;
          phase  <= phase + 1'b1;
          if (lastTick) busy <= 1'b0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.clear  = startNow;
    strb.decide = tick && (phase >= PH_W'(TRACK_CYC));
    strb.bitIdx = IDX_W'(CODE_W - 1 - (int'(phase) - TRACK_CYC));
    strb.finish = lastTick;
  end

  // R6: done lasts a single cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6: every end of busy comes with done
  assert_done_on_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R5: a running conversion is never restarted by a new trigger
  assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastTick) |=> (busy && (phase == $past(phase) || phase == $past(phase) + 1'b1)));
  // R3: reserved modes never start
  assert_reserved_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startMode[2:1] == 2'b11) |=> !busy);
endmodule

// File: rtl/adc_fmt_dp.sv
module adc_fmt_dp
  import adc_ctrl_pkg::*;
#(
  parameter int NEG_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [CODE_W-1:0] rawCode,
  input  logic [NEG_W-1:0]  negSel,
  input  logic              leftJust,
  output logic [OUT_W-1:0]  resultPair
);
  logic [CODE_W-1:0] sarReg;
  logic [CODE_W-1:0] sarNext;
  logic [OUT_W-1:0]  fmtWord;
  logic              isDiff;
  logic [PAD_W-1:0]  signFill;

  // behavioural stand-in for the comparator: one bit resolved per decision
  always_comb begin
    sarNext = sarReg;
    if (strb.decide) sarNext[strb.bitIdx] = rawCode[strb.bitIdx];
  end

  assign isDiff = (negSel != '0);

  for (genvar g = 0; g < PAD_W; g++) begin : gFill
    assign signFill[g] = isDiff & sarNext[CODE_W-1];
  end

  assign fmtWord = leftJust ? {sarNext, {PAD_W{1'b0}}} : {signFill, sarNext};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg     <= '0;
      resultPair <= '0;
    end else begin
      if (strb.clear)       sarReg <= '0;
      else if (strb.decide) sarReg <= sarNext;
      if (strb.finish) resultPair <= fmtWord;
    end
  end

  // R10: the pair only moves on completion
  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> $stable(resultPair));
  // R8: left alignment leaves the low bits clear
  assert_left_low_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && leftJust) |=> (resultPair[PAD_W-1:0] == '0));
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int SEL_W     = 5,
  parameter int TRACK_CYC = 3,
  parameter int NEG_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        startMode,
  input  logic              swStart,
  input  logic              tmr0Ovf,
  input  logic              tmr1Ovf,
  input  logic              tmr2Ovf,
  input  logic              tmr3Ovf,
  input  logic              extStart,
  input  logic [SEL_W-1:0]  clkSel,
  input  logic [NEG_W-1:0]  negSel,
  input  logic              leftJust,
  input  logic [CODE_W-1:0] rawCode,
  output logic              busy,
  output logic              done,
  output logic [7:0]        resultHi,
  output logic [7:0]        resultLo
);
  ctlStrobes_t      strb;
  logic [OUT_W-1:0] resultPair;

  adc_ctrl_seq #(.SEL_W(SEL_W), .TRACK_CYC(TRACK_CYC)) u_seq (
    .clk(clk), .rstN(rstN), .startMode(startMode), .swStart(swStart),
    .tmr0Ovf(tmr0Ovf), .tmr1Ovf(tmr1Ovf), .tmr2Ovf(tmr2Ovf), .tmr3Ovf(tmr3Ovf),
    .extStart(extStart), .clkSel(clkSel), .busy(busy), .done(done), .strb(strb)
  );

  adc_fmt_dp #(.NEG_W(NEG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rawCode(rawCode), .negSel(negSel),
    .leftJust(leftJust), .resultPair(resultPair)
  );

  assign resultHi = resultPair[OUT_W-1:OUT_W-8];
  assign resultLo = resultPair[7:0];
endmodule

// File: tb/sim_adc_conv_ctrl.sv
`timescale 1ns/1ps
module sim_adc_conv_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] startMode = 3'd0;
  logic       swStart = 0, tmr0Ovf = 0, tmr1Ovf = 0, tmr2Ovf = 0, tmr3Ovf = 0, extStart = 0;
  logic [4:0] clkSel = 5'd0;
  logic [3:0] negSel = 4'd0;
  logic       leftJust = 1'b0;
  logic [9:0] rawCode = 10'd0;
  logic       busy, done;
  logic [7:0] resultHi, resultLo;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_conv_ctrl u0 (
    .clk(clk), .rstN(rstN), .startMode(startMode), .swStart(swStart),
    .tmr0Ovf(tmr0Ovf), .tmr1Ovf(tmr1Ovf), .tmr2Ovf(tmr2Ovf), .tmr3Ovf(tmr3Ovf),
    .extStart(extStart), .clkSel(clkSel), .negSel(negSel), .leftJust(leftJust),
    .rawCode(rawCode), .busy(busy), .done(done), .resultHi(resultHi), .resultLo(resultLo)
  );

  // entries: {differential, leftJust, raw code, expected pair}
  localparam logic [27:0] VEC [14] = '{
    {1'b0, 1'b0, 10'h3FF, 16'h03FF}, {1'b0, 1'b0, 10'h200, 16'h0200},
    {1'b0, 1'b0, 10'h100, 16'h0100}, {1'b0, 1'b0, 10'h000, 16'h0000},
    {1'b0, 1'b1, 10'h3FF, 16'hFFC0}, {1'b0, 1'b1, 10'h200, 16'h8000},
    {1'b0, 1'b1, 10'h100, 16'h4000}, {1'b1, 1'b0, 10'h1FF, 16'h01FF},
    {1'b1, 1'b0, 10'h300, 16'hFF00}, {1'b1, 1'b0, 10'h200, 16'hFE00},
    {1'b1, 1'b1, 10'h1FF, 16'h7FC0}, {1'b1, 1'b1, 10'h300, 16'hC000},
    {1'b1, 1'b1, 10'h200, 16'h8000}, {1'b1, 1'b0, 10'h000, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // drive one source high for a single rising edge; returns at the next falling edge
  task automatic pulse(input int src);
    case (src)
      0: swStart = 1; 1: tmr0Ovf = 1; 2: tmr1Ovf = 1; 3: tmr2Ovf = 1; default: tmr3Ovf = 1;
    endcase
    @(negedge clk);
    swStart = 0; tmr0Ovf = 0; tmr1Ovf = 0; tmr2Ovf = 0; tmr3Ovf = 0;
  endtask

  // counts busy cycles from now until done; optionally raises tmr0Ovf once when len == pokeAt
  task automatic measure(input int pokeAt, output int len, output int doneCnt);
    bit poked = 0;
    len = busy ? 1 : 0;
    doneCnt = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (busy) len++;
      if (done) begin doneCnt++; tmr0Ovf = 0; break; end
      if (len == pokeAt && !poked) begin tmr0Ovf = 1; poked = 1; end
      else tmr0Ovf = 0;
    end
  endtask

  // watches for any busy over n cycles
  task automatic idle_watch(input int n, output bit sawBusy);
    sawBusy = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) sawBusy = 1;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int len, dn;
    bit saw;
    logic [15:0] held;
    int waitN;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset busy", busy, 0);
    check("R10 reset done", done, 0);
    check("R10 reset pair", {resultHi, resultLo}, 16'h0000);
    rstN = 1;
    @(negedge clk);

    // R7 R8 R9: formatting table, software start
    startMode = 3'd0;
    for (int v = 0; v < 14; v++) begin
      negSel   = VEC[v][27] ? 4'd3 : 4'd0;
      leftJust = VEC[v][26];
      rawCode  = VEC[v][25:16];
      pulse(0);
      measure(-1, len, dn);
      check(VEC[v][27] ? (VEC[v][26] ? "R8 diff left" : "R9 diff right")
                       : (VEC[v][26] ? "R8 se left" : "R7 se right"),
            {resultHi, resultLo}, VEC[v][15:0]);
      if (v == 0) begin
        check("R4 length sel0", len, 13);
        check("R6 one done", dn, 1);
      end
    end

    // R10: pair holds while inputs move and no conversion runs
    held = {resultHi, resultLo};
    rawCode = 10'h155; leftJust = 0; negSel = 0;
    repeat (5) @(negedge clk);
    check("R10 hold", {resultHi, resultLo}, held);

    // R4: divider lengths
    clkSel = 5'd3; pulse(0); measure(-1, len, dn);
    check("R4 length sel3", len, 52);
    clkSel = 5'd31; pulse(0); measure(-1, len, dn);
    check("R4 length sel31", len, 416);
    check("R7 code after long run", {resultHi, resultLo}, 16'h0155);
    clkSel = 5'd0;

    // R1: each timer mode on its own source, and the wrong source does nothing
    startMode = 3'd1; pulse(1); measure(-1, len, dn); check("R1 mode001 tmr0", len, 13);
    startMode = 3'd2; pulse(3); measure(-1, len, dn); check("R1 mode010 tmr2", len, 13);
    startMode = 3'd3; pulse(2); measure(-1, len, dn); check("R1 mode011 tmr1", len, 13);
    startMode = 3'd5; pulse(4); measure(-1, len, dn); check("R1 mode101 tmr3", len, 13);
    startMode = 3'd2; pulse(1); pulse(2); pulse(0); pulse(4);
    idle_watch(20, saw);
    check("R1 unselected sources", saw, 0);

    // R3: reserved modes
    for (int m = 6; m < 8; m++) begin
      startMode = 3'(m);
      for (int s = 0; s < 5; s++) pulse(s);
      extStart = 1; idle_watch(8, saw); extStart = 0;
      idle_watch(4, saw);
      check("R3 reserved mode", saw, 0);
    end

    // R2: external pin rising edge, held high
    startMode = 3'd4;
    extStart = 1;
    waitN = 0;
    while (!busy && waitN < 10) begin @(negedge clk); waitN++; end
    check("R2 ext start latency ok", (waitN <= 4) ? 1 : 0, 1);
    measure(-1, len, dn);
    check("R2 ext length", len, 13);
    idle_watch(40, saw);
    check("R2 held high no retrigger", saw, 0);
    extStart = 0;
    idle_watch(4, saw);

    // R5: triggers mid-conversion and in the last busy cycle are ignored
    startMode = 3'd1;
    pulse(1); measure(6, len, dn);
    check("R5 mid trigger length", len, 13);
    check("R5 mid trigger one done", dn, 1);
    pulse(1); measure(13, len, dn);
    check("R5 last-cycle trigger one done", dn, 1);
    idle_watch(15, saw);
    check("R5 last-cycle trigger ignored", saw, 0);

    // R6: trigger held through completion restarts immediately
    rawCode = 10'h2AA; negSel = 0; leftJust = 0;
    tmr0Ovf = 1;
    @(negedge clk);
    len = 1; dn = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (busy) len++;
      if (done) begin dn = 1; break; end
    end
    check("R6 first length", len, 13);
    check("R6 done while busy low", busy, 0);
    check("R10 first result in done cycle", {resultHi, resultLo}, 16'h02AA);
    rawCode = 10'h0F0;
    @(negedge clk);
    tmr0Ovf = 0;
    check("R6 back-to-back restart", busy, 1);
    check("R6 done gone", done, 0);
    measure(-1, len, dn);
    check("R6 second length", len, 13);
    check("R10 second result", {resultHi, resultLo}, 16'h00F0);

    finish_run();
  end
endmodule